// File: doc/BRIEF.md
# PC Card Host Bus Decoder

This block sits between the host side of a PC Card style serial card and its internals. It samples the active-low host strobes, the two card enables and the attribute/register select on every clock. Each qualified cycle goes either to a small attribute memory or to the register port of a UART core. Memory cycles index the attribute bytes with host address bits 8..1. I/O cycles pass address bits 2..0 to the UART. In the legacy COM-port decode, the upper address bits must also match a base address.

The card starts unconfigured and ignores all I/O cycles. A host write to the configuration byte of attribute memory enables the card and picks card-I/O or COM-port decode. The block drives the active-low input-acknowledge during decoded I/O reads and the enable for the read-data driver. It raises a sticky interrupt toward the local subsystem whenever the host writes attribute memory. The active-low host interrupt pin reports busy for a fixed time after reset and then carries the UART interrupt.

Top module: `pccard_host_if`

## Requirements
- R1: A UART write pulse (`uart_wr` high for one cycle) comes one cycle after the first sampled cycle of a qualified I/O write. A qualified I/O write has `iowr_n`, `reg_n` and at least one card enable low, `iord_n` high, the card configured, and the address decoded. `uart_addr` carries host address bits 2..0 and `uart_wdata` the write byte.
- R2: A UART read pulse (`uart_rd` high for one cycle) comes one cycle after the first sampled cycle of a qualified I/O read. The conditions mirror R1 with the two I/O strobes swapped. A strobe held for several cycles gives a single pulse.
- R3: `io_ack_n` is low one cycle after each sampled cycle of a qualified I/O read and high at all other times. During such a read, `host_rdata` returns `uart_rdata` one cycle later.
- R4: While unconfigured, I/O cycles are ignored: `io_ack_n` stays high, no UART pulses occur and `host_data_oe` stays low.
- R5: The configuration byte is attribute byte index CFG_INDEX (default 0, an even host address). Bit 0 = 1 configures the card. Bit 1 selects the decode: 0 = card I/O, 1 = COM port.
- R6: In COM-port decode, an I/O cycle is accepted only when address bits 9..3 equal bits 9..3 of COM_BASE (default 0x3F8). In card-I/O decode, bits 9..3 are ignored.
- R7: A qualified attribute write has `reg_n`, a card enable and `we_n` low, and `oe_n` high. It stores `host_wdata` at byte index = address bits 8..1; address bits 9 and 0 have no effect. A qualified attribute read (`oe_n` low, `we_n` high) returns that byte on `host_rdata` one cycle later.
- R8: `host_data_oe` is high one cycle after a sampled qualified attribute read or qualified I/O read. It is never high after a cycle in which `we_n` or `iowr_n` was low, or both card enables were high.
- R9: `sub_irq` rises one cycle after any qualified attribute write. It holds until `sub_irq_clr` is sampled high in a cycle with no attribute write. A write in the same cycle as a clear keeps it high.
- R10: `host_irq_n` is low during reset and for the first 16 rising edges after reset is released. From then on it equals the inverse of `uart_irq` sampled one cycle earlier.
- R11: Reset clears every attribute byte and returns the card to the unconfigured state. It sets `io_ack_n` high and `host_data_oe`, `sub_irq`, `uart_rd` and `uart_wr` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Active-high master reset |
| host_addr | input | 10 | Host address |
| host_wdata | input | 8 | Host write data |
| reg_n | input | 1 | Attribute/register select, active low |
| ce1_n | input | 1 | Card enable 1, active low |
| ce2_n | input | 1 | Card enable 2, active low |
| oe_n | input | 1 | Memory read strobe, active low |
| we_n | input | 1 | Memory write strobe, active low |
| iord_n | input | 1 | I/O read strobe, active low |
| iowr_n | input | 1 | I/O write strobe, active low |
| host_rdata | output | 8 | Read data toward the host |
| host_data_oe | output | 1 | Enable for the host data driver |
| io_ack_n | output | 1 | Input acknowledge, active low |
| host_irq_n | output | 1 | Ready/busy, then host interrupt, active low |
| sub_irq | output | 1 | Interrupt to the local subsystem |
| sub_irq_clr | input | 1 | Subsystem clears `sub_irq` |
| uart_addr | output | 3 | UART register select |
| uart_wdata | output | 8 | UART write data |
| uart_rd | output | 1 | UART read pulse |
| uart_wr | output | 1 | UART write pulse |
| uart_rdata | input | 8 | UART read data |
| uart_irq | input | 1 | UART interrupt, active high |

## Verification
Every registered output is due one rising edge after the edge at which its inputs were sampled. The one exception is the busy-to-ready hand-over of `host_irq_n`, which is due at the sixteenth edge after reset release. The bench changes inputs on falling edges. At each rising edge, a behavioural model works out the next expected values from the inputs it has just seen. One nanosecond later the bench compares those values with every output. Directed checks in the stimulus tasks sample at the same point, after the first edge of each strobe. There they confirm the single-cycle UART pulses and the unchanged outputs for ignored cycles.

// File: rtl/pchi_pkg.sv
package pchi_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 10;
    localparam int UREG_W  = 3;
    localparam int IDX_LO  = 1;
    localparam int IDX_W   = 8;
    localparam int ATTR_DEPTH = 1 << IDX_W;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef struct packed {
        byte_t             rdata;
        logic              data_oe;
        logic              ack_n;
        logic [UREG_W-1:0] uaddr;
        byte_t             uwdata;
        logic              urd;
        logic              uwr;
        logic              prev_ior;
        logic              prev_iow;
        logic              sub_irq;
        logic              irq_n;
    } hif_regs_t;

    localparam hif_regs_t HIF_RESET = '{
        rdata: '0, data_oe: 1'b0, ack_n: 1'b1, uaddr: '0, uwdata: '0,
        urd: 1'b0, uwr: 1'b0, prev_ior: 1'b0, prev_iow: 1'b0,
        sub_irq: 1'b0, irq_n: 1'b1
    };
endpackage

// File: rtl/pchi_decode.sv
module pchi_decode
    import pchi_pkg::*;
#(
    parameter logic [ADDR_W-1:0] COM_BASE = 10'h3F8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              reg_n,
    input  logic              ce1_n,
    input  logic              ce2_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              iord_n,
    input  logic              iowr_n,
    input  logic              cfg_en,
    input  logic              cfg_com,
    output logic              attr_rd,
    output logic              attr_wr,
    output logic              io_rd,
    output logic              io_wr,
    output idx_t              attr_idx
);
    localparam int HI_LO = UREG_W;

    logic card_sel;
    logic io_hit;

    always_comb begin
        card_sel = ~reg_n & ~(ce1_n & ce2_n);
        io_hit   = cfg_en &
                   (~cfg_com | (addr[ADDR_W-1:HI_LO] == COM_BASE[ADDR_W-1:HI_LO]));
        attr_rd  = card_sel & ~oe_n & we_n;
        attr_wr  = card_sel & ~we_n & oe_n;
        io_rd    = card_sel & io_hit & ~iord_n & iowr_n;
        io_wr    = card_sel & io_hit & ~iowr_n & iord_n;
        attr_idx = addr[IDX_LO +: IDX_W];
    end
endmodule

// File: rtl/pchi_attr_mem.sv
module pchi_attr_mem
    import pchi_pkg::*;
#(
    parameter int   DEPTH     = ATTR_DEPTH,
    parameter idx_t CFG_INDEX = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  idx_t  wr_idx,
    input  byte_t wr_data,
    input  idx_t  rd_idx,
    output byte_t rd_data,
    output logic  cfg_en,
    output logic  cfg_com
);
    byte_t mem_q [DEPTH];
    byte_t mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en) begin
            mem_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_data = mem_q[rd_idx];
    assign cfg_en  = mem_q[CFG_INDEX][0];
    assign cfg_com = mem_q[CFG_INDEX][1];
endmodule

// File: rtl/pchi_init_timer.sv
module pchi_init_timer #(
    parameter int INIT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    output logic ready
);
    localparam int CW = $clog2(INIT_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ready;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!tmr_q.ready) begin
            tmr_d.cnt   = tmr_q.cnt + 1'b1;
            tmr_d.ready = (tmr_q.cnt == CW'(INIT_CYCLES - 1));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign ready = tmr_q.ready;
endmodule

// File: rtl/pccard_host_if.sv
module pccard_host_if
    import pchi_pkg::*;
#(
    parameter logic [ADDR_W-1:0] COM_BASE    = 10'h3F8,
    parameter idx_t              CFG_INDEX   = '0,
    parameter int                INIT_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              reg_n,
    input  logic              ce1_n,
    input  logic              ce2_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              iord_n,
    input  logic              iowr_n,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_data_oe,
    output logic              io_ack_n,
    output logic              host_irq_n,
    output logic              sub_irq,
    input  logic              sub_irq_clr,
    output logic [UREG_W-1:0] uart_addr,
    output logic [DATA_W-1:0] uart_wdata,
    output logic              uart_rd,
    output logic              uart_wr,
    input  logic [DATA_W-1:0] uart_rdata,
    input  logic              uart_irq
);
    logic  attr_rd, attr_wr, io_rd, io_wr;
    logic  cfg_en, cfg_com, ready;
    idx_t  attr_idx;
    byte_t mem_rd;

    hif_regs_t r_d, r_q;

    pchi_decode #(.COM_BASE(COM_BASE)) u_dec (
        .addr    (host_addr),
        .reg_n   (reg_n),
        .ce1_n   (ce1_n),
        .ce2_n   (ce2_n),
        .oe_n    (oe_n),
        .we_n    (we_n),
        .iord_n  (iord_n),
        .iowr_n  (iowr_n),
        .cfg_en  (cfg_en),
        .cfg_com (cfg_com),
        .attr_rd (attr_rd),
        .attr_wr (attr_wr),
        .io_rd   (io_rd),
        .io_wr   (io_wr),
        .attr_idx(attr_idx)
    );

    pchi_attr_mem #(.DEPTH(ATTR_DEPTH), .CFG_INDEX(CFG_INDEX)) u_mem (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (attr_wr),
        .wr_idx (attr_idx),
        .wr_data(host_wdata),
        .rd_idx (attr_idx),
        .rd_data(mem_rd),
        .cfg_en (cfg_en),
        .cfg_com(cfg_com)
    );

    pchi_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .ready(ready)
    );

    always_comb begin
        r_d          = r_q;
        r_d.rdata    = attr_rd ? mem_rd : uart_rdata;
        r_d.data_oe  = (attr_rd | io_rd) & we_n & iowr_n & ~(ce1_n & ce2_n);
        r_d.ack_n    = ~io_rd;
        r_d.uaddr    = host_addr[UREG_W-1:0];
        r_d.uwdata   = host_wdata;
        r_d.urd      = io_rd & ~r_q.prev_ior;
        r_d.uwr      = io_wr & ~r_q.prev_iow;
        r_d.prev_ior = io_rd;
        r_d.prev_iow = io_wr;
        if (attr_wr) begin
            r_d.sub_irq = 1'b1;
        end else if (sub_irq_clr) begin
            r_d.sub_irq = 1'b0;
        end
        r_d.irq_n    = ~uart_irq;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= HIF_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign host_rdata   = r_q.rdata;
    assign host_data_oe = r_q.data_oe;
    assign io_ack_n     = r_q.ack_n;
    assign host_irq_n   = ready ? r_q.irq_n : 1'b0;
    assign sub_irq      = r_q.sub_irq;
    assign uart_addr    = r_q.uaddr;
    assign uart_wdata   = r_q.uwdata;
    assign uart_rd      = r_q.urd;
    assign uart_wr      = r_q.uwr;
endmodule

// File: rtl/pccard_host_if_chk.sv
module pccard_host_if_chk #(
    parameter int INIT_CYCLES = 16
) (
    input logic clk,
    input logic rst,
    input logic reg_n,
    input logic ce1_n,
    input logic ce2_n,
    input logic we_n,
    input logic iord_n,
    input logic iowr_n,
    input logic host_data_oe,
    input logic io_ack_n,
    input logic host_irq_n,
    input logic sub_irq,
    input logic sub_irq_clr,
    input logic uart_rd,
    input logic uart_wr,
    input logic cfg_en
);
    logic [7:0] since_rel;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rel <= '0;
        end else if (since_rel != 8'hFF) begin
            since_rel <= since_rel + 8'd1;
        end
    end

    p_wr_single_r1: assert property (@(posedge clk) disable iff (rst)
        uart_wr |=> !uart_wr);
    p_rd_single_r2: assert property (@(posedge clk) disable iff (rst)
        uart_rd |=> !uart_rd);
    p_ack_from_read_r3: assert property (@(posedge clk) disable iff (rst)
        !io_ack_n |-> ($past(!iord_n) && $past(!reg_n)));
    p_ack_needs_cfg_r4: assert property (@(posedge clk) disable iff (rst)
        !io_ack_n |-> $past(cfg_en));
    p_oe_no_write_r8: assert property (@(posedge clk) disable iff (rst)
        host_data_oe |-> ($past(we_n) && $past(iowr_n)));
    p_oe_needs_ce_r8: assert property (@(posedge clk) disable iff (rst)
        host_data_oe |-> !$past(ce1_n && ce2_n));
    p_sub_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (sub_irq && !sub_irq_clr) |=> sub_irq);
    p_busy_window_r10: assert property (@(posedge clk) disable iff (rst)
        (since_rel < 8'(INIT_CYCLES)) |-> !host_irq_n);
endmodule

bind pccard_host_if pccard_host_if_chk #(.INIT_CYCLES(INIT_CYCLES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_n       (reg_n),
    .ce1_n       (ce1_n),
    .ce2_n       (ce2_n),
    .we_n        (we_n),
    .iord_n      (iord_n),
    .iowr_n      (iowr_n),
    .host_data_oe(host_data_oe),
    .io_ack_n    (io_ack_n),
    .host_irq_n  (host_irq_n),
    .sub_irq     (sub_irq),
    .sub_irq_clr (sub_irq_clr),
    .uart_rd     (uart_rd),
    .uart_wr     (uart_wr),
    .cfg_en      (cfg_en)
);

// File: tb/pccard_host_if_test.sv
`timescale 1ns/1ps
module pccard_host_if_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       reg_n = 1'b1, ce1_n = 1'b1, ce2_n = 1'b1;
    logic       oe_n = 1'b1, we_n = 1'b1, iord_n = 1'b1, iowr_n = 1'b1;
    logic       sub_irq_clr = 1'b0;
    logic [7:0] uart_rdata = 8'h3C;
    logic       uart_irq = 1'b0;
    logic [7:0] host_rdata;
    logic       host_data_oe, io_ack_n, host_irq_n, sub_irq, uart_rd, uart_wr;
    logic [2:0] uart_addr;
    logic [7:0] uart_wdata;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    pccard_host_if uut (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
        .reg_n(reg_n), .ce1_n(ce1_n), .ce2_n(ce2_n), .oe_n(oe_n), .we_n(we_n),
        .iord_n(iord_n), .iowr_n(iowr_n), .host_rdata(host_rdata),
        .host_data_oe(host_data_oe), .io_ack_n(io_ack_n), .host_irq_n(host_irq_n),
        .sub_irq(sub_irq), .sub_irq_clr(sub_irq_clr), .uart_addr(uart_addr),
        .uart_wdata(uart_wdata), .uart_rd(uart_rd), .uart_wr(uart_wr),
        .uart_rdata(uart_rdata), .uart_irq(uart_irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    logic [7:0] m_mem [256];
    logic [7:0] m_rdata, m_wdata;
    logic [2:0] m_uaddr;
    logic m_oe, m_ack_n, m_rd, m_wr, m_sub, m_irqn, m_pr, m_pw;
    int   m_cnt;

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_mem[i]) m_mem[i] = 8'h00;
            m_rdata = 0; m_wdata = 0; m_uaddr = 0;
            m_oe = 0; m_ack_n = 1; m_rd = 0; m_wr = 0; m_sub = 0;
            m_irqn = 1; m_pr = 0; m_pw = 0; m_cnt = 0;
        end else begin
            bit sel, conf, com, dec, ior, iow, ard, awr;
            sel  = !reg_n && (!ce1_n || !ce2_n);
            conf = m_mem[0][0];
            com  = m_mem[0][1];
            dec  = conf && (!com || host_addr[9:3] == 7'h7F);
            ior  = sel && dec && !iord_n && iowr_n;
            iow  = sel && dec && !iowr_n && iord_n;
            ard  = sel && !oe_n && we_n;
            awr  = sel && !we_n && oe_n;
            m_rdata = ard ? m_mem[host_addr[8:1]] : uart_rdata;
            m_oe    = (ard || ior) && we_n && iowr_n;
            m_ack_n = !ior;
            m_rd    = ior && !m_pr;
            m_wr    = iow && !m_pw;
            m_pr    = ior;
            m_pw    = iow;
            m_uaddr = host_addr[2:0];
            m_wdata = host_wdata;
            if (awr) m_sub = 1; else if (sub_irq_clr) m_sub = 0;
            if (awr) m_mem[host_addr[8:1]] = host_wdata;
            m_irqn = !uart_irq;
            if (m_cnt < 1000) m_cnt++;
        end
        #1;
        if (!done) begin
            chk("R7 host_rdata", host_rdata, m_rdata);
            chk("R8 host_data_oe", host_data_oe, m_oe);
            chk("R3 io_ack_n", io_ack_n, m_ack_n);
            chk("R2 uart_rd", uart_rd, m_rd);
            chk("R1 uart_wr", uart_wr, m_wr);
            chk("R1 uart_addr", uart_addr, m_uaddr);
            chk("R1 uart_wdata", uart_wdata, m_wdata);
            chk("R9 sub_irq", sub_irq, m_sub);
            chk("R10 host_irq_n", host_irq_n, (m_cnt >= 16) ? m_irqn : 1'b0);
        end
    end

    task automatic idle();
        reg_n = 1; ce1_n = 1; ce2_n = 1; oe_n = 1; we_n = 1;
        iord_n = 1; iowr_n = 1; sub_irq_clr = 0;
    endtask

    task automatic attr_wr(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk); idle(); reg_n = 0; ce1_n = 0; we_n = 0;
        host_addr = a; host_wdata = d;
        @(negedge clk); @(negedge clk); idle();
    endtask

    task automatic attr_rd(input logic [9:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); idle(); reg_n = 0; ce2_n = 0; oe_n = 0; host_addr = a;
        @(posedge clk); #1;
        chk(tag, host_data_oe, 1);
        chk(tag, host_rdata, exp);
        @(negedge clk); idle();
    endtask

    task automatic io_rd(input logic [9:0] a, input bit hit, input string tag);
        @(negedge clk); idle(); reg_n = 0; ce1_n = 0; iord_n = 0; host_addr = a;
        @(posedge clk); #1;
        chk(tag, io_ack_n, !hit);
        chk(tag, uart_rd, hit);
        chk(tag, host_data_oe, hit);
        if (hit) chk(tag, host_rdata, uart_rdata);
        @(posedge clk); #1;
        chk(tag, uart_rd, 0);
        chk(tag, io_ack_n, !hit);
        @(negedge clk); idle();
    endtask

    task automatic io_wr(input logic [9:0] a, input logic [7:0] d, input bit hit, input string tag);
        @(negedge clk); idle(); reg_n = 0; ce2_n = 0; iowr_n = 0;
        host_addr = a; host_wdata = d;
        @(posedge clk); #1;
        chk(tag, uart_wr, hit);
        chk(tag, host_data_oe, 0);
        if (hit) begin chk(tag, uart_addr, a[2:0]); chk(tag, uart_wdata, d); end
        @(posedge clk); #1;
        chk(tag, uart_wr, 0);
        @(negedge clk); idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(posedge clk); #1;
        chk("R11 reset io_ack_n", io_ack_n, 1);
        chk("R11 reset oe", host_data_oe, 0);
        chk("R11 reset sub_irq", sub_irq, 0);
        chk("R10 busy after reset", host_irq_n, 0);
        repeat (20) @(negedge clk);
        chk("R10 ready", host_irq_n, 1);

        io_rd(10'h3F9, 0, "R4 unconfigured read");
        io_wr(10'h001, 8'h11, 0, "R4 unconfigured write");

        attr_wr(10'h20B, 8'hA5);
        chk("R9 set by attr write", sub_irq, 1);
        attr_rd(10'h00A, 8'hA5, "R7 index from bits 8..1");
        repeat (3) @(negedge clk);
        chk("R9 held", sub_irq, 1);
        sub_irq_clr = 1; @(negedge clk); sub_irq_clr = 0;
        chk("R9 cleared", sub_irq, 0);
        @(negedge clk); reg_n = 0; ce1_n = 0; we_n = 0; sub_irq_clr = 1;
        host_addr = 10'h010; host_wdata = 8'h77;
        @(negedge clk); idle();
        chk("R9 write wins over clear", sub_irq, 1);

        @(negedge clk); reg_n = 0; we_n = 0; host_addr = 10'h00A; host_wdata = 8'hEE;
        @(negedge clk); idle();
        attr_rd(10'h00A, 8'hA5, "R8 no card enable ignores write");
        @(negedge clk); reg_n = 0; ce1_n = 0; oe_n = 0; we_n = 0; host_addr = 10'h00A;
        @(posedge clk); #1;
        chk("R8 no oe with write strobe", host_data_oe, 0);
        @(negedge clk); idle();

        attr_wr(10'h000, 8'h01);
        io_wr(10'h123, 8'h5A, 1, "R1 card io write");
        uart_rdata = 8'hC3;
        io_rd(10'h005, 1, "R2 R3 card io read");
        @(negedge clk); reg_n = 0; ce1_n = 0; iord_n = 0; iowr_n = 0;
        @(posedge clk); #1;
        chk("R3 both io strobes no ack", io_ack_n, 1);
        @(negedge clk); idle();

        attr_wr(10'h001, 8'h03);
        io_rd(10'h3FA, 1, "R6 com base hit");
        io_rd(10'h2FA, 0, "R6 com base miss");
        io_wr(10'h3FF, 8'h42, 1, "R5 com mode write");

        uart_irq = 1;
        @(negedge clk); @(negedge clk);
        chk("R10 follows uart irq", host_irq_n, 0);
        uart_irq = 0;

        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk); rst = 0;
        repeat (18) @(negedge clk);
        io_rd(10'h3F8, 0, "R11 unconfigured after reset");
        attr_rd(10'h00A, 8'h00, "R11 memory cleared");

        repeat (2) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule